// File: doc/BRIEF.md
# Send DMA Engine State Controller

This block sequences a send DMA engine through bring-up, idle, running, halting and the two-stage clean-up that follows a stop or an error. Software and engine status logic deliver one event per cycle as an encoded strobe. The controller steps a seven-state machine and decodes the engine's control levels (enable, interrupt enable, halt, drain) from the current state. It also issues single-cycle action pulses that start hardware start-up, hardware clean-up and software clean-up. The work each pulse starts is done elsewhere, and its completion comes back to this block as an event.

A sticky run request flag records whether running was asked for. Go-running sets it and go-idle clears it while the engine is in a wait state. When start-up completes, this flag decides between idle and running. The previous state and the most recent event code are held in registers for debug readout.

Top module: `dma_state_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, state_o is 0 (down), run_req_o is 0, all four control outputs and all three pulses are 0, prev_state_o is 0 and last_event_o is 0.
- R2: State codes are down=0, start-up wait=1, idle=2, software clean-up wait=3, hardware clean-up wait=4, halt wait=5, running=6. Event codes are go-down=0, go-start=1, started=2, go-run=3, sw-cleaned=4, hw-cleaned=5, halted=6, go-idle=7, error-A=8, error-B=9, tick=10. In down, go-start moves to start-up wait, and go-run does the same and also sets run_req_o. Every other event leaves down unchanged.
- R3: In start-up wait, started moves to running when run_req_o is 1, and to idle when it is 0.
- R4: In start-up wait and in the halt, hardware clean-up and software clean-up waits, go-run sets run_req_o and go-idle clears it. Neither changes the state.
- R5: In idle, go-run moves to running and sets run_req_o.
- R6: In running, halted or error-A moves to software clean-up wait and pulses sw_clean_o.
- R7: In running, go-idle moves to halt wait and clears run_req_o. Error-B moves to halt wait and leaves run_req_o unchanged.
- R8: In halt wait, halted moves to hardware clean-up wait and pulses hw_clean_o. In hardware clean-up wait, hw-cleaned moves to software clean-up wait and pulses sw_clean_o.
- R9: In software clean-up wait, sw-cleaned moves to start-up wait and pulses hw_start_o.
- R10: Go-down moves any other state to down. It pulses sw_clean_o only when leaving running, halt wait or hardware clean-up wait.
- R11: Tick, codes 11 to 15, and events that have no transition in the current state change neither the state nor run_req_o.
- R12: The control outputs {eng_enable_o, eng_int_en_o, eng_halt_o, eng_drain_o} follow the state as follows: down 0000, start-up wait 0100, idle 1100, running 1100, halt wait 0111, hardware clean-up wait 0110, software clean-up wait 0110.
- R13: Each action pulse lasts exactly one cycle, and no two pulses are high together. prev_state_o holds the state that was left at the most recent transition. last_event_o holds the code of the most recent strobed event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event strobe, one event per cycle |
| evt_code_i | input | EVT_W | Event code |
| state_o | output | 3 | Current state code |
| run_req_o | output | 1 | Sticky run request flag |
| eng_enable_o | output | 1 | Engine enable |
| eng_int_en_o | output | 1 | Engine interrupt enable |
| eng_halt_o | output | 1 | Engine halt |
| eng_drain_o | output | 1 | Engine drain |
| hw_start_o | output | 1 | Pulse: begin hardware start-up and buffer disarm |
| hw_clean_o | output | 1 | Pulse: begin hardware clean-up |
| sw_clean_o | output | 1 | Pulse: begin software clean-up |
| prev_state_o | output | 3 | State left at the last transition |
| last_event_o | output | EVT_W | Code of the last strobed event |

## Verification
The assertions rely on one property of the input: at most one event arrives per cycle. The encoded event port guarantees this, so the transition and pulse properties never have to weigh two competing events. They also assume that codes above 10 are harmless. The bench keeps inside these limits: it drives one code per strobe on the falling clock edge, drops the strobe before the next event, and sends out-of-range codes only to confirm that they have no effect.

// File: rtl/dma_state_pkg.sv
package dma_state_pkg;
  localparam int unsigned ST_W    = 3;
  localparam int unsigned NUM_EVT = 11;

  typedef enum logic [ST_W-1:0] {
    ST_DOWN  = 3'd0,
    ST_BOOT  = 3'd1,
    ST_IDLE  = 3'd2,
    ST_SWCLN = 3'd3,
    ST_HWCLN = 3'd4,
    ST_HALT  = 3'd5,
    ST_RUN   = 3'd6
  } st_e;

  localparam int unsigned E_DOWN    = 0;
  localparam int unsigned E_START   = 1;
  localparam int unsigned E_STARTED = 2;
  localparam int unsigned E_RUN     = 3;
  localparam int unsigned E_SWDONE  = 4;
  localparam int unsigned E_HWDONE  = 5;
  localparam int unsigned E_HALTED  = 6;
  localparam int unsigned E_IDLE    = 7;
  localparam int unsigned E_ERR_A   = 8;
  localparam int unsigned E_ERR_B   = 9;
  localparam int unsigned E_TICK    = 10;

  typedef struct packed {
    logic enable;
    logic int_en;
    logic halt;
    logic drain;
  } ctl_t;

  typedef struct packed {
    logic hw_start;
    logic hw_clean;
    logic sw_clean;
  } act_t;
endpackage

// File: rtl/dma_evt_decode.sv
module dma_evt_decode #(
  parameter int unsigned EVT_W   = 4,
  parameter int unsigned NUM_EVT = 11
) (
  input  logic               valid_i,
  input  logic [EVT_W-1:0]   code_i,
  output logic [NUM_EVT-1:0] hit_o
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_hit
    assign hit_o[i] = valid_i && (code_i == EVT_W'(i));
  end
endmodule

// File: rtl/dma_ctl_table.sv
module dma_ctl_table
  import dma_state_pkg::*;
(
  input  st_e  state_i,
  output ctl_t ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (state_i)
      ST_BOOT:  ctl_o = '{enable: 1'b0, int_en: 1'b1, halt: 1'b0, drain: 1'b0};
      ST_IDLE,
      ST_RUN:   ctl_o = '{enable: 1'b1, int_en: 1'b1, halt: 1'b0, drain: 1'b0};
      ST_HALT:  ctl_o = '{enable: 1'b0, int_en: 1'b1, halt: 1'b1, drain: 1'b1};
      ST_HWCLN,
      ST_SWCLN: ctl_o = '{enable: 1'b0, int_en: 1'b1, halt: 1'b1, drain: 1'b0};
      default:  ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_state_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] hit_i,
  output st_e              state_o,
  output st_e              prev_o,
  output logic             run_req_o,
  output act_t             act_o
);
  st_e  state_q, state_d, prev_q;
  logic run_q, run_d;
  act_t act_q, act_d;

  // go-run / go-idle bookkeeping shared by all wait states
  function automatic logic flag_upd(logic cur, logic go_run, logic go_idle);
    if (go_run)  return 1'b1;
    if (go_idle) return 1'b0;
    return cur;
  endfunction

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    act_d   = '0;
    unique case (state_q)
      ST_DOWN: begin
        if (hit_i[E_RUN]) begin
          run_d   = 1'b1;
          state_d = ST_BOOT;
        end else if (hit_i[E_START]) begin
          state_d = ST_BOOT;
        end
      end
      ST_BOOT: begin
        if (hit_i[E_DOWN])         state_d = ST_DOWN;
        else if (hit_i[E_STARTED]) state_d = run_q ? ST_RUN : ST_IDLE;
        else run_d = flag_upd(run_q, hit_i[E_RUN], hit_i[E_IDLE]);
      end
      ST_IDLE: begin
        if (hit_i[E_DOWN]) state_d = ST_DOWN;
        else if (hit_i[E_RUN]) begin
          state_d = ST_RUN;
          run_d   = 1'b1;
        end
      end
      ST_SWCLN: begin
        if (hit_i[E_DOWN]) state_d = ST_DOWN;
        else if (hit_i[E_SWDONE]) begin
          state_d        = ST_BOOT;
          act_d.hw_start = 1'b1;
        end else run_d = flag_upd(run_q, hit_i[E_RUN], hit_i[E_IDLE]);
      end
      ST_HWCLN: begin
        if (hit_i[E_DOWN] || hit_i[E_HWDONE]) begin
          state_d        = hit_i[E_DOWN] ? ST_DOWN : ST_SWCLN;
          act_d.sw_clean = 1'b1;
        end else run_d = flag_upd(run_q, hit_i[E_RUN], hit_i[E_IDLE]);
      end
      ST_HALT: begin
        if (hit_i[E_DOWN]) begin
          state_d        = ST_DOWN;
          act_d.sw_clean = 1'b1;
        end else if (hit_i[E_HALTED]) begin
          state_d        = ST_HWCLN;
          act_d.hw_clean = 1'b1;
        end else run_d = flag_upd(run_q, hit_i[E_RUN], hit_i[E_IDLE]);
      end
      ST_RUN: begin
        if (hit_i[E_DOWN]) begin
          state_d        = ST_DOWN;
          act_d.sw_clean = 1'b1;
        end else if (hit_i[E_HALTED] || hit_i[E_ERR_A]) begin
          state_d        = ST_SWCLN;
          act_d.sw_clean = 1'b1;
        end else if (hit_i[E_IDLE]) begin
          state_d = ST_HALT;
          run_d   = 1'b0;
        end else if (hit_i[E_ERR_B]) begin
          state_d = ST_HALT;
        end
      end
      default: state_d = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DOWN;
      prev_q  <= ST_DOWN;
      run_q   <= 1'b0;
      act_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      act_q   <= act_d;
      if (state_d != state_q) prev_q <= state_q;
    end
  end

  assign state_o   = state_q;
  assign prev_o    = prev_q;
  assign run_req_o = run_q;
  assign act_o     = act_q;
endmodule

// File: rtl/dma_state_ctrl.sv
module dma_state_ctrl
  import dma_state_pkg::*;
#(
  parameter int unsigned EVT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [EVT_W-1:0] evt_code_i,
  output logic [ST_W-1:0]  state_o,
  output logic             run_req_o,
  output logic             eng_enable_o,
  output logic             eng_int_en_o,
  output logic             eng_halt_o,
  output logic             eng_drain_o,
  output logic             hw_start_o,
  output logic             hw_clean_o,
  output logic             sw_clean_o,
  output logic [ST_W-1:0]  prev_state_o,
  output logic [EVT_W-1:0] last_event_o
);
  logic [NUM_EVT-1:0] hit;
  st_e                state, prev;
  act_t               act;
  ctl_t               ctl;
  logic [EVT_W-1:0]   last_evt_q;

  dma_evt_decode #(.EVT_W(EVT_W), .NUM_EVT(NUM_EVT)) u_dec (
    .valid_i (evt_valid_i),
    .code_i  (evt_code_i),
    .hit_o   (hit)
  );

  dma_seq_fsm #(.N_EVT(NUM_EVT)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .state_o   (state),
    .prev_o    (prev),
    .run_req_o (run_req_o),
    .act_o     (act)
  );

  dma_ctl_table u_tbl (
    .state_i (state),
    .ctl_o   (ctl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_evt_q <= '0;
    else if (evt_valid_i) last_evt_q <= evt_code_i;
  end

  assign state_o      = state;
  assign prev_state_o = prev;
  assign last_event_o = last_evt_q;
  assign eng_enable_o = ctl.enable;
  assign eng_int_en_o = ctl.int_en;
  assign eng_halt_o   = ctl.halt;
  assign eng_drain_o  = ctl.drain;
  assign hw_start_o   = act.hw_start;
  assign hw_clean_o   = act.hw_clean;
  assign sw_clean_o   = act.sw_clean;
endmodule

// File: rtl/dma_state_ctrl_chk.sv
module dma_state_ctrl_chk
  import dma_state_pkg::*;
#(
  parameter int unsigned EVT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic [EVT_W-1:0] evt_code_i,
  input logic [ST_W-1:0]  state_o,
  input logic             run_req_o,
  input logic             eng_enable_o,
  input logic             eng_int_en_o,
  input logic             eng_halt_o,
  input logic             eng_drain_o,
  input logic             hw_start_o,
  input logic             hw_clean_o,
  input logic             sw_clean_o
);
  p_pulse_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hw_start_o, hw_clean_o, sw_clean_o}));

  p_hw_start_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_start_o |-> (state_o == ST_BOOT) && ($past(state_o) == ST_SWCLN));

  p_hw_clean_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clean_o |-> (state_o == ST_HWCLN) && ($past(state_o) == ST_HALT));

  p_sw_clean_dst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clean_o |-> (state_o == ST_SWCLN) || (state_o == ST_DOWN));

  p_enable_states_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_enable_o |-> (state_o == ST_IDLE) || (state_o == ST_RUN));

  p_drain_halt_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_drain_o |-> eng_halt_o && (state_o == ST_HALT));

  p_down_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DOWN) |-> !eng_enable_o && !eng_int_en_o && !eng_halt_o);

  p_run_needs_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN) && ($past(state_o) != ST_RUN) |-> run_req_o);

  p_tick_inert_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && (evt_code_i == EVT_W'(E_TICK)) |=> $stable(state_o) && $stable(run_req_o));
endmodule

bind dma_state_ctrl dma_state_ctrl_chk #(.EVT_W(EVT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_valid_i  (evt_valid_i),
  .evt_code_i   (evt_code_i),
  .state_o      (state_o),
  .run_req_o    (run_req_o),
  .eng_enable_o (eng_enable_o),
  .eng_int_en_o (eng_int_en_o),
  .eng_halt_o   (eng_halt_o),
  .eng_drain_o  (eng_drain_o),
  .hw_start_o   (hw_start_o),
  .hw_clean_o   (hw_clean_o),
  .sw_clean_o   (sw_clean_o)
);

// File: tb/dma_state_ctrl_tb.sv
module dma_state_ctrl_tb;
  localparam int EVT_W = 4;
  localparam int DOWN = 0, START = 1, STARTED = 2, GORUN = 3, SWDONE = 4, HWDONE = 5,
                 HALTED = 6, GOIDLE = 7, ERRA = 8, ERRB = 9, TICK = 10;
  localparam int S_DOWN = 0, S_BOOT = 1, S_IDLE = 2, S_SW = 3, S_HW = 4, S_HALT = 5, S_RUN = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [EVT_W-1:0] evt_code = '0;
  logic [2:0] state, prev_state;
  logic run_req, en, ien, halt, drain, hw_start, hw_clean, sw_clean;
  logic [EVT_W-1:0] last_event;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_state_ctrl #(.EVT_W(EVT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_code_i(evt_code),
    .state_o(state), .run_req_o(run_req), .eng_enable_o(en), .eng_int_en_o(ien),
    .eng_halt_o(halt), .eng_drain_o(drain), .hw_start_o(hw_start), .hw_clean_o(hw_clean),
    .sw_clean_o(sw_clean), .prev_state_o(prev_state), .last_event_o(last_event)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int code);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_code  = EVT_W'(code);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  function automatic int ctl();
    return int'({en, ien, halt, drain});
  endfunction

  function automatic int pulses();
    return int'({hw_start, hw_clean, sw_clean});
  endfunction

  task automatic t_reset();
    chk("R1 state", state, S_DOWN);
    chk("R1 run flag", run_req, 0);
    chk("R1 ctl", ctl(), 0);
    chk("R1 pulses", pulses(), 0);
    chk("R1 prev", prev_state, 0);
    chk("R1 last evt", last_event, 0);
  endtask

  task automatic t_down_ignore();
    int codes[9] = '{STARTED, SWDONE, HWDONE, HALTED, GOIDLE, ERRA, ERRB, TICK, 13};
    foreach (codes[i]) begin
      send(codes[i]);
      chk("R2 down holds", state, S_DOWN);
      chk("R11 flag holds", run_req, 0);
      chk("R11 no pulse", pulses(), 0);
    end
  endtask

  task automatic t_bringup_idle();
    send(START);
    chk("R2 start", state, S_BOOT);
    chk("R2 flag", run_req, 0);
    chk("R12 boot ctl", ctl(), 4'b0100);
    chk("R13 prev", prev_state, S_DOWN);
    chk("R13 last evt", last_event, START);
    send(STARTED);
    chk("R3 to idle", state, S_IDLE);
    chk("R12 idle ctl", ctl(), 4'b1100);
    send(GOIDLE);
    chk("R11 idle ignores go-idle", state, S_IDLE);
  endtask

  task automatic t_idle_run();
    send(GORUN);
    chk("R5 running", state, S_RUN);
    chk("R5 flag", run_req, 1);
    chk("R12 run ctl", ctl(), 4'b1100);
    send(TICK);
    chk("R11 tick", state, S_RUN);
    send(15);
    chk("R11 code 15", state, S_RUN);
  endtask

  task automatic t_halt_path();
    send(GOIDLE);
    chk("R7 halt wait", state, S_HALT);
    chk("R7 flag clear", run_req, 0);
    chk("R12 halt ctl", ctl(), 4'b0111);
    send(GORUN);
    chk("R4 halt go-run", state, S_HALT);
    chk("R4 flag set", run_req, 1);
    send(GOIDLE);
    chk("R4 flag clear", run_req, 0);
    send(HALTED);
    chk("R8 hw wait", state, S_HW);
    chk("R8 hw_clean", pulses(), 3'b010);
    chk("R12 hw ctl", ctl(), 4'b0110);
    @(negedge clk);
    chk("R13 pulse width", pulses(), 0);
    send(HWDONE);
    chk("R8 sw wait", state, S_SW);
    chk("R8 sw_clean", pulses(), 3'b001);
    send(SWDONE);
    chk("R9 boot", state, S_BOOT);
    chk("R9 hw_start", pulses(), 3'b100);
    send(STARTED);
    chk("R3 flag0 to idle", state, S_IDLE);
  endtask

  task automatic t_err_paths();
    send(GORUN);
    send(ERRA);
    chk("R6 err-A", state, S_SW);
    chk("R6 sw_clean", pulses(), 3'b001);
    chk("R12 sw ctl", ctl(), 4'b0110);
    send(GOIDLE);
    chk("R4 sw wait clear", run_req, 0);
    chk("R4 sw wait holds", state, S_SW);
    send(GORUN);
    chk("R4 sw wait set", run_req, 1);
    send(SWDONE);
    send(GOIDLE);
    chk("R4 boot clear", run_req, 0);
    send(GORUN);
    chk("R4 boot set", run_req, 1);
    chk("R4 boot holds", state, S_BOOT);
    send(STARTED);
    chk("R3 flag1 to run", state, S_RUN);
    send(ERRB);
    chk("R7 err-B", state, S_HALT);
    chk("R7 flag kept", run_req, 1);
    chk("R7 no pulse", pulses(), 0);
  endtask

  task automatic t_go_down();
    send(DOWN);
    chk("R10 halt->down", state, S_DOWN);
    chk("R10 halt pulse", pulses(), 3'b001);
    send(GORUN);
    chk("R2 go-run boot", state, S_BOOT);
    chk("R2 go-run flag", run_req, 1);
    send(DOWN);
    chk("R10 boot->down", state, S_DOWN);
    chk("R10 boot no pulse", pulses(), 0);
    send(START);
    send(STARTED);
    chk("R3 run", state, S_RUN);
    send(DOWN);
    chk("R10 run->down", state, S_DOWN);
    chk("R10 run pulse", pulses(), 3'b001);
    chk("R13 prev run", prev_state, S_RUN);
    send(START);
    send(GOIDLE);
    send(STARTED);
    send(DOWN);
    chk("R10 idle->down", state, S_DOWN);
    chk("R10 idle no pulse", pulses(), 0);
    send(START);
    send(GORUN);
    send(STARTED);
    send(HALTED);
    chk("R6 halted", state, S_SW);
    send(DOWN);
    chk("R10 sw->down", state, S_DOWN);
    chk("R10 sw no pulse", pulses(), 0);
    send(START);
    send(STARTED);
    send(ERRB);
    send(HALTED);
    send(DOWN);
    chk("R10 hw->down", state, S_DOWN);
    chk("R10 hw pulse", pulses(), 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_down_ignore();
    t_bringup_idle();
    t_idle_run();
    t_halt_path();
    t_err_paths();
    t_go_down();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule